// File: doc/BRIEF.md
# Processor Trap Entry and Exit Sequencer

This block decides when a pipelined processor takes a trap and what happens to the machine state around that moment. A vector of trap sources is reduced to a single request, which counts only while a software-controlled enable bit is set. An accepted request tells the pipeline to drop the write-back of the instruction now computing. It also raises a one-cycle backup strobe, which stops the next call-hardware update and starts the call-hardware rollback. At the same time it sets a freeze flag that holds the registers the handler must save.

A copy of the freeze flag, delayed by one cycle, holds a cause register. That register records which sources were active and keeps the value until software has saved it. Once the handler has saved the state, software releases the freeze. To return, it starts the exit sequence, which waits a fixed number of cycles so the pipeline can refill. The sequence then restores the enable bit on its own. Software can also set the enable bit directly to allow nested traps.

Top module: `trap_sequencer`

## Requirements
- R1: After reset, trapEn is 1, and backupStrobe, freezeRegs, freezeDly, exitBusy and cause are all 0.
- R2: abortWb is 1 in the same cycle that trapEn is 1 and at least one bit of trapSrc is 1. In every other cycle it is 0.
- R3: On the clock edge that accepts a request, backupStrobe rises. It is 1 for exactly one cycle.
- R4: The edge that accepts a request clears trapEn.
- R5: The edge that accepts a request sets freezeRegs. It stays 1 until a cycle with freezeClr high, and the edge that ends that cycle clears it.
- R6: freezeDly equals the value freezeRegs had one cycle earlier.
- R7: At every edge where freezeDly is 0, cause loads trapSrc. While freezeDly is 1, cause holds its value. After a trap, cause therefore shows trapSrc as it was in the cycle after the accepted request.
- R8: While trapEn is 0, trapSrc has no effect on abortWb, backupStrobe or freezeRegs.
- R9: An exitStart write makes exitBusy 1 for exactly EXIT_LEN (default 2) cycles. The edge that drops exitBusy sets trapEn.
- R10: An enSet write sets trapEn at the next edge.
- R11: An exitStart write while exitBusy is 1 is ignored and does not lengthen the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapSrc | input | NSRC | Trap source lines |
| enSet | input | 1 | Software write: set trap enable |
| freezeClr | input | 1 | Software write: release the state freeze |
| exitStart | input | 1 | Software write: begin the exit sequence |
| abortWb | output | 1 | Suppress write-back of the computing instruction |
| backupStrobe | output | 1 | One-cycle call-hardware backup and update inhibit |
| freezeRegs | output | 1 | Freeze enable for state to be saved |
| freezeDly | output | 1 | Freeze delayed one cycle |
| trapEn | output | 1 | Trap enable bit |
| exitBusy | output | 1 | Exit sequence in progress |
| cause | output | NSRC | Latched trap-source register (read-only) |

## Verification
The bench drives a trap with every trap-source pattern. Between the accepting edge and the following edge it changes the sources, so a cause register that freezes one cycle early or late shows the wrong pattern. It also checks that sources are ignored while the enable bit is clear. If the strobe were not derived from the enable bit, it would last more than one cycle or trap a second time. The exit sequence is checked for its exact length and for a repeated start write in the middle: an off-by-one counter would restore the enable bit on the wrong edge, and a design that restarts its counter would stay busy too long.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef struct packed {
    logic causeHold;
  } trap_ctrl_t;
endpackage

// File: rtl/trap_cause_dp.sv
module trap_cause_dp #(
  parameter int NSRC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NSRC-1:0]     trapSrc,
  input  trap_pkg::trap_ctrl_t ctrl,
  output logic                anySrc,
  output logic [NSRC-1:0]     cause
);
  assign anySrc = |trapSrc;

  always_ff @(posedge clk) begin
    if (!rstN)
      cause <= '0;
    else if (!ctrl.causeHold)
      cause <= trapSrc;
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int EXIT_LEN = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 anySrc,
  input  logic                 enSet,
  input  logic                 freezeClr,
  input  logic                 exitStart,
  output logic                 abortWb,
  output logic                 backupStrobe,
  output logic                 freezeRegs,
  output logic                 freezeDly,
  output logic                 trapEn,
  output logic                 exitBusy,
  output trap_pkg::trap_ctrl_t ctrl
);
  localparam int CW = $clog2(EXIT_LEN + 1);
  localparam logic [CW-1:0] LEN = CW'(EXIT_LEN);

  logic [CW-1:0] exitCnt;
  logic          trapReq;
  logic          exitDone;

  assign trapReq  = anySrc && trapEn;
  assign abortWb  = trapReq;
  assign exitBusy = (exitCnt != '0);
  assign exitDone = (exitCnt == CW'(1));
  assign ctrl.causeHold = freezeDly;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapEn       <= 1'b1;
      backupStrobe <= 1'b0;
      freezeRegs   <= 1'b0;
      freezeDly    <= 1'b0;
      exitCnt      <= '0;
    end else begin
      backupStrobe <= trapReq;
      freezeDly    <= freezeRegs;

      if (trapReq)        freezeRegs <= 1'b1;
      else if (freezeClr) freezeRegs <= 1'b0;

      if (exitBusy)       exitCnt <= exitCnt - CW'(1);
      else if (exitStart) exitCnt <= LEN;

      if (trapReq)                  trapEn <= 1'b0;
      else if (exitDone || enSet)   trapEn <= 1'b1;
    end
  end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer #(
  parameter int NSRC     = 4,
  parameter int EXIT_LEN = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] trapSrc,
  input  logic            enSet,
  input  logic            freezeClr,
  input  logic            exitStart,
  output logic            abortWb,
  output logic            backupStrobe,
  output logic            freezeRegs,
  output logic            freezeDly,
  output logic            trapEn,
  output logic            exitBusy,
  output logic [NSRC-1:0] cause
);
  trap_pkg::trap_ctrl_t ctrl;
  logic anySrc;

  trap_ctrl #(.EXIT_LEN(EXIT_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .anySrc(anySrc), .enSet(enSet),
    .freezeClr(freezeClr), .exitStart(exitStart), .abortWb(abortWb),
    .backupStrobe(backupStrobe), .freezeRegs(freezeRegs),
    .freezeDly(freezeDly), .trapEn(trapEn), .exitBusy(exitBusy), .ctrl(ctrl)
  );

  trap_cause_dp #(.NSRC(NSRC)) u_dp (
    .clk(clk), .rstN(rstN), .trapSrc(trapSrc), .ctrl(ctrl),
    .anySrc(anySrc), .cause(cause)
  );
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [NSRC-1:0] trapSrc,
  input logic            abortWb,
  input logic            backupStrobe,
  input logic            freezeRegs,
  input logic            freezeDly,
  input logic            trapEn,
  input logic            exitBusy,
  input logic [NSRC-1:0] cause
);
  AST_ABORT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (!trapEn || trapSrc == '0) |-> !abortWb); // R8
  AST_ENTRY_EFFECTS: assert property (@(posedge clk) disable iff (!rstN)
    abortWb |=> (backupStrobe && !trapEn && freezeRegs)); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    backupStrobe |=> !backupStrobe); // R3
  AST_FREEZE_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    freezeRegs |=> freezeDly); // R6
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    freezeDly |=> (cause == $past(cause))); // R7
  AST_EXIT_RESTORES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(exitBusy) |-> trapEn); // R9
endmodule

bind trap_sequencer trap_sequencer_chk #(.NSRC(NSRC)) i_chk (
  .clk(clk), .rstN(rstN), .trapSrc(trapSrc), .abortWb(abortWb),
  .backupStrobe(backupStrobe), .freezeRegs(freezeRegs), .freezeDly(freezeDly),
  .trapEn(trapEn), .exitBusy(exitBusy), .cause(cause)
);

// File: tb/test_trap_sequencer.sv
`timescale 1ns/1ps
module test_trap_sequencer;
  localparam int NSRC = 4;
  logic clk = 0, rstN = 0;
  logic [NSRC-1:0] trapSrc = '0;
  logic enSet = 0, freezeClr = 0, exitStart = 0;
  logic abortWb, backupStrobe, freezeRegs, freezeDly, trapEn, exitBusy;
  logic [NSRC-1:0] cause;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  trap_sequencer #(.NSRC(NSRC), .EXIT_LEN(2)) i_trap_sequencer (
    .clk(clk), .rstN(rstN), .trapSrc(trapSrc), .enSet(enSet),
    .freezeClr(freezeClr), .exitStart(exitStart), .abortWb(abortWb),
    .backupStrobe(backupStrobe), .freezeRegs(freezeRegs),
    .freezeDly(freezeDly), .trapEn(trapEn), .exitBusy(exitBusy), .cause(cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    rstN = 1; #1;
    chk("R1 trapEn", trapEn, 1); chk("R1 strobe", backupStrobe, 0);
    chk("R1 freeze", freezeRegs, 0); chk("R1 freezeDly", freezeDly, 0);
    chk("R1 exitBusy", exitBusy, 0); chk("R1 cause", cause, 0);

    for (int v = 0; v < 16; v++) begin
      logic [NSRC-1:0] p, q;
      p = NSRC'(v); q = ~p;
      trapSrc = p; #1;
      chk("R2 abort", abortWb, (p != 0));
      if (p == 0) begin
        step();
        chk("R2 no strobe", backupStrobe, 0);
        chk("R1 en kept", trapEn, 1);
        continue;
      end
      step();
      chk("R3 strobe", backupStrobe, 1);
      chk("R4 en clear", trapEn, 0);
      chk("R5 freeze", freezeRegs, 1);
      chk("R6 dly", freezeDly, 0);
      chk("R7 cause", cause, p);
      trapSrc = q; #1;
      chk("R8 abort masked", abortWb, 0);
      step();
      chk("R3 strobe once", backupStrobe, 0);
      chk("R6 dly", freezeDly, 1);
      chk("R7 cause after", cause, q);
      trapSrc = p;
      step();
      chk("R7 cause held", cause, q);
      chk("R8 freeze stays", freezeRegs, 1);
      chk("R8 no strobe", backupStrobe, 0);
      freezeClr = 1; step(); freezeClr = 0;
      chk("R5 freeze clr", freezeRegs, 0);
      chk("R6 dly lag", freezeDly, 1);
      step();
      chk("R6 dly clr", freezeDly, 0);
      trapSrc = '0;
      step();
      chk("R7 cause resample", cause, 0);
      if (v % 2 == 1) begin
        enSet = 1; step(); enSet = 0;
        chk("R10 en set", trapEn, 1);
        chk("R10 no exit", exitBusy, 0);
      end else begin
        exitStart = 1; step(); exitStart = (v % 4 == 2);
        chk("R9 busy1", exitBusy, 1); chk("R9 en low", trapEn, 0);
        step(); exitStart = 0;
        chk("R9 busy2", exitBusy, 1); chk("R9 en low2", trapEn, 0);
        step();
        chk("R11 busy end", exitBusy, 0); chk("R9 en restored", trapEn, 1);
        step();
        chk("R11 not restarted", exitBusy, 0);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule